// File: doc/BRIEF.md
# Two-Wire Command and Response Slave

This block is a slave on a two-wire serial bus (I2C). It lets an external host deliver command packets to the chip and read response bytes back. The bus wires are sampled on the chip's system clock, which must run at least twenty times faster than the bus clock. Both wires pass through synchronizer flops. The block finds START and STOP conditions on the synchronized wires and reacts to the 7-bit device address that follows each START. The upper five address bits are fixed at `11000`. Two strap inputs supply the lower two bits, so four of these slaves can share one bus.

A write transaction carries one command code followed by any number of argument bytes. Each byte leaves on a command stream: one cycle of `cmd_valid` per byte, with `cmd_first` on the command code and `cmd_last` on the final byte. The block holds one byte back. It sends that byte on when the next byte completes, or, flagged as last, when the transaction ends. The bus cannot be stretched, so the command stream has no back-pressure. The sink must take a beat in any cycle where `cmd_valid` is high.

A read transaction pulls bytes from a response source through a ready/valid handshake. `rsp_ready` is high for one cycle each time the block needs a byte, and a transfer happens in that cycle only if `rsp_valid` is also high. If no byte is offered, the block sends 0xFF and consumes nothing. The source may change `rsp_valid` and `rsp_data` at any time between fetches. Reading continues until the host answers a byte with a NACK.

Top module: `i2c_cmd_slave`

## Requirements
- R1: After reset, `sda_oe`, `cmd_valid`, `cmd_first`, `cmd_last` and `rsp_ready` are all 0.
- R2: The first byte after START is taken MSB first on SCL rising edges. Bits [7:1] are the address and bit [0] is R/W (1 = read, 0 = write). If bits [7:1] equal {5'b11000, strap_a1, strap_a0}, the slave pulls SDA low for the whole ninth clock pulse (ACK).
- R3: If the address does not match, the slave gives no ACK. Until the next START it drives SDA for no bit, emits no command beat and asserts no `rsp_ready`.
- R4: In a write, every data byte is ACKed and appears once on `cmd_data`, MSB first as received. The first data byte carries `cmd_first`=1 and every later byte carries `cmd_first`=0.
- R5: The last data byte of a write carries `cmd_last`=1. It is emitted after a STOP or a repeated START. Every other byte carries `cmd_last`=0, and each `cmd_valid` pulse lasts one cycle.
- R6: In a read, each byte goes out MSB first. The slave changes SDA only while SCL is low.
- R7: `rsp_ready` rises for one cycle per byte sent. When `rsp_valid` is high in that cycle, `rsp_data` is sent and consumed. Otherwise 0xFF is sent and nothing is consumed.
- R8: A host ACK after a read byte fetches the next byte. A host NACK makes the slave release SDA and fetch no further byte.
- R9: A repeated START at any point restarts address reception, and a write in progress is closed as with a STOP.
- R10: After STOP, SDA is released and the slave ignores the bus until the next START.
- R11: SDA is open drain. `sda_oe`=1 pulls the line low, and `sda_oe`=0 leaves it to the pull-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull data line low when 1 |
| strap_a1 | input | 1 | Address bit 1 strap |
| strap_a0 | input | 1 | Address bit 0 strap |
| cmd_valid | output | 1 | One-cycle beat carrying a received byte |
| cmd_data | output | 8 | Received byte |
| cmd_first | output | 1 | Beat is the command code |
| cmd_last | output | 1 | Beat is the final byte of the write |
| rsp_ready | output | 1 | Slave takes a response byte this cycle |
| rsp_valid | input | 1 | Response byte is offered |
| rsp_data | input | 8 | Offered response byte |

## Verification
A bit counter that drifts by one shifts every later byte. The damage shows within a single byte period, either as a corrupted `cmd_data` value or as an ACK in the wrong clock pulse, which the host sees at once. A state machine that misses a STOP or a NACK shows up as a stray `sda_oe` while SCL is high, or as an extra `rsp_ready` pulse, in the very next bus clock. A lost holding register shows up as a missing or misflagged `cmd_last` beat a few system cycles after the STOP.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] RSP_FILL = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain   <= '1;
        prev[g] <= 1'b1;
      end else begin
        chain   <= {chain[STAGES-2:0], raw[g]};
        prev[g] <= chain[STAGES-1];
      end
    end
    assign synced[g] = chain[STAGES-1];
  end

  assign scl_s     = synced[0];
  assign sda_s     = synced[1];
  assign scl_rise  = synced[0] & ~prev[0];
  assign scl_fall  = ~synced[0] & prev[0];
  assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_cmd_pkg::*;
#(
  parameter logic [ADDR_W-3:0] ADDR_FIXED = 5'b11000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [1:0]        strap,
  output logic              sda_oe,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_first,
  output logic              rsp_ready,
  input  logic              rsp_valid,
  input  logic [BYTE_W-1:0] rsp_data
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  slv_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              rx_full;
  logic              rw_read;
  logic              first_pend;
  logic [ADDR_W-1:0] dev_addr;
  logic [BYTE_W-1:0] next_byte;
  logic              fetch_now;

  assign dev_addr  = {ADDR_FIXED, strap};
  assign next_byte = rsp_valid ? rsp_data : RSP_FILL;
  assign fetch_now = scl_fall &&
                     ((state == ST_ADDR_ACK && rw_read) || state == ST_RD_ACK);
  assign rsp_ready = fetch_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      rx_full    <= 1'b0;
      rw_read    <= 1'b0;
      first_pend <= 1'b0;
      sda_oe     <= 1'b0;
      byte_done  <= 1'b0;
      byte_data  <= '0;
      byte_first <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        rx_full <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        rx_full <= 1'b0;
        sda_oe  <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WR_BYTE: begin
            if (scl_rise && !rx_full) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST_BIT) rx_full <= 1'b1;
            end else if (scl_fall && rx_full) begin
              rx_full <= 1'b0;
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (rx_sh[BYTE_W-1:1] == dev_addr) begin
                  sda_oe     <= 1'b1;
                  rw_read    <= rx_sh[0];
                  first_pend <= ~rx_sh[0];
                  state      <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                byte_done  <= 1'b1;
                byte_data  <= rx_sh;
                byte_first <= first_pend;
                first_pend <= 1'b0;
                sda_oe     <= 1'b1;
                state      <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              if (fetch_now) begin
                tx_sh   <= next_byte;
                sda_oe  <= ~next_byte[BYTE_W-1];
                bit_cnt <= '0;
                state   <= ST_RD_BYTE;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WR_BYTE;
              end
            end
          end
          ST_RD_BYTE: begin
            if (scl_fall) begin
              if (bit_cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
                sda_oe  <= ~tx_sh[BYTE_W-2];
                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise && sda_s) begin
              state <= ST_IDLE;
            end else if (fetch_now) begin
              tx_sh   <= next_byte;
              sda_oe  <= ~next_byte[BYTE_W-1];
              bit_cnt <= '0;
              state   <= ST_RD_BYTE;
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_framer.sv
module i2c_cmd_framer
  import i2c_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_first,
  input  logic              flush,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_data,
  output logic              cmd_first,
  output logic              cmd_last
);
  logic              held_v;
  logic [BYTE_W-1:0] held_d;
  logic              held_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_v    <= 1'b0;
      held_d    <= '0;
      held_f    <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
      cmd_first <= 1'b0;
      cmd_last  <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      cmd_first <= 1'b0;
      cmd_last  <= 1'b0;
      if (byte_done) begin
        if (held_v) begin
          cmd_valid <= 1'b1;
          cmd_data  <= held_d;
          cmd_first <= held_f;
        end
        held_v <= 1'b1;
        held_d <= byte_data;
        held_f <= byte_first;
      end else if (flush && held_v) begin
        cmd_valid <= 1'b1;
        cmd_data  <= held_d;
        cmd_first <= held_f;
        cmd_last  <= 1'b1;
        held_v    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave
  import i2c_cmd_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [4:0]       ADDR_FIXED  = 5'b11000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       strap_a1,
  input  logic       strap_a0,
  output logic       cmd_valid,
  output logic [7:0] cmd_data,
  output logic       cmd_first,
  output logic       cmd_last,
  output logic       rsp_ready,
  input  logic       rsp_valid,
  input  logic [7:0] rsp_data
);
  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_data;
  logic              byte_first;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slave_ctrl #(.ADDR_FIXED(ADDR_FIXED)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap({strap_a1, strap_a0}), .sda_oe(sda_oe), .byte_done(byte_done),
    .byte_data(byte_data), .byte_first(byte_first), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  i2c_cmd_framer u_frame (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_data(byte_data),
    .byte_first(byte_first), .flush(start_det | stop_det),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_first(cmd_first),
    .cmd_last(cmd_last)
  );
endmodule

// File: rtl/i2c_cmd_slave_chk.sv
module i2c_cmd_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic cmd_valid,
  input logic cmd_first,
  input logic cmd_last,
  input logic rsp_ready
);
  AST_OE_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe)); // R6
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R10
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe); // R9
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R5
  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_first || cmd_last) |-> cmd_valid); // R4
  AST_FETCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready); // R7
endmodule

bind i2c_cmd_slave i2c_cmd_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .cmd_valid(cmd_valid),
  .cmd_first(cmd_first), .cmd_last(cmd_last), .rsp_ready(rsp_ready)
);

// File: tb/i2c_cmd_slave_test.sv
module i2c_cmd_slave_test;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic strap_a1 = 1'b0;
  logic strap_a0 = 1'b0;
  logic sda_oe, cmd_valid, cmd_first, cmd_last, rsp_ready, rsp_valid;
  logic [7:0] cmd_data, rsp_data;
  logic sda_line;

  logic [7:0] rsp_q [0:15];
  int rsp_ptr = 0;
  int rsp_avail = 0;
  logic [7:0] log_d [0:255];
  logic log_f [0:255];
  logic log_l [0:255];
  int n_log = 0;
  int n_fetch = 0;
  int n_oe_bad = 0;
  logic [7:0] wbuf [0:7];
  int checks = 0;
  int fails = 0;
  logic prev_scl = 1'b1;
  logic prev_oe = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = sda_drv & ~sda_oe;
  assign rsp_valid = rsp_ptr < rsp_avail;
  assign rsp_data = rsp_q[rsp_ptr[3:0]];

  i2c_cmd_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_a1(strap_a1), .strap_a0(strap_a0),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_first(cmd_first),
    .cmd_last(cmd_last), .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  always @(posedge clk) if (rsp_ready && rsp_valid) rsp_ptr <= rsp_ptr + 1;

  always @(negedge clk) begin
    if (cmd_valid) begin
      log_d[n_log[7:0]] = cmd_data;
      log_f[n_log[7:0]] = cmd_first;
      log_l[n_log[7:0]] = cmd_last;
      n_log = n_log + 1;
    end
    if (rsp_ready) n_fetch = n_fetch + 1;
    if (scl_drv && prev_scl && sda_oe != prev_oe) n_oe_bad = n_oe_bad + 1;
    prev_scl = scl_drv;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit addr_hit(input logic [6:0] a, input logic s1, input logic s0);
    return a == {5'b11000, s1, s0};
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic h_start;
    sda_drv = 1'b1; wclk(H); scl_drv = 1'b1; wclk(H);
    sda_drv = 1'b0; wclk(H); scl_drv = 1'b0; wclk(2);
  endtask

  task automatic h_stop;
    sda_drv = 1'b0; wclk(H); scl_drv = 1'b1; wclk(H); sda_drv = 1'b1; wclk(H);
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; wclk(H); scl_drv = 1'b1; wclk(H); scl_drv = 1'b0; wclk(2);
  endtask

  task automatic recv_bit(output logic b);
    sda_drv = 1'b1; wclk(H); scl_drv = 1'b1; wclk(H / 2);
    b = sda_line; wclk(H / 2); scl_drv = 1'b0; wclk(2);
  endtask

  task automatic write_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic read_byte(input bit host_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~host_ack);
  endtask

  task automatic do_write(input logic [6:0] a, input int n);
    bit ack;
    bit hit;
    int base;
    int fbase;
    hit = addr_hit(a, strap_a1, strap_a0);
    base = n_log;
    fbase = n_fetch;
    h_start();
    write_byte({a, 1'b0}, ack);
    chk(ack == hit, hit ? "R2 addr ack" : "R3 no ack", int'(ack), int'(hit));
    if (hit) begin
      for (int i = 0; i < n; i++) begin
        write_byte(wbuf[i], ack);
        chk(ack, "R4 data ack", int'(ack), 1);
      end
    end else begin
      write_byte(8'hA5, ack);
      chk(!ack, "R3 data ignored", int'(ack), 0);
    end
    h_stop();
    wclk(8);
    chk(sda_oe == 1'b0, "R10 released after stop", int'(sda_oe), 0);
    chk(n_fetch == fbase, "R3 no fetch on write", n_fetch - fbase, 0);
    if (hit) begin
      chk(n_log - base == n, "R5 beat count", n_log - base, n);
      for (int i = 0; i < n && base + i < n_log; i++) begin
        chk(log_d[base + i] == wbuf[i], "R4 byte value", int'(log_d[base + i]), int'(wbuf[i]));
        chk(log_f[base + i] == (i == 0), "R4 first flag", int'(log_f[base + i]), int'(i == 0));
        chk(log_l[base + i] == (i == n - 1), "R5 last flag", int'(log_l[base + i]), int'(i == n - 1));
      end
    end else begin
      chk(n_log == base, "R3 no beats", n_log - base, 0);
    end
  endtask

  task automatic do_read(input logic [6:0] a, input int n, input int avail, input bool_restart);
    bit ack;
    bit hit;
    int fbase;
    logic [7:0] d;
    logic [7:0] exp;
    hit = addr_hit(a, strap_a1, strap_a0);
    for (int i = 0; i < 16; i++) rsp_q[i] = 8'($urandom);
    rsp_ptr = 0;
    rsp_avail = avail;
    fbase = n_fetch;
    if (!bool_restart) h_start();
    else begin
      sda_drv = 1'b1; wclk(H); scl_drv = 1'b1; wclk(H);
      sda_drv = 1'b0; wclk(H); scl_drv = 1'b0; wclk(2);
    end
    write_byte({a, 1'b1}, ack);
    chk(ack == hit, hit ? "R2 read addr ack" : "R3 read no ack", int'(ack), int'(hit));
    if (hit) begin
      for (int i = 0; i < n; i++) begin
        read_byte(i < n - 1, d);
        exp = (i < avail) ? rsp_q[i] : 8'hFF;
        chk(d == exp, i < avail ? "R6 read byte" : "R7 fill byte", int'(d), int'(exp));
      end
      chk(sda_oe == 1'b0, "R8 released after nack", int'(sda_oe), 0);
      chk(n_fetch - fbase == n, "R8 fetch count", n_fetch - fbase, n);
      chk(rsp_ptr == ((n < avail) ? n : avail), "R7 consumed", rsp_ptr, (n < avail) ? n : avail);
    end else begin
      read_byte(1'b0, d);
      chk(d == 8'hFF, "R3 line idle", int'(d), 255);
      chk(n_fetch == fbase, "R3 no fetch", n_fetch - fbase, 0);
    end
    h_stop();
    wclk(8);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    bit ack;
    int base;
    logic [7:0] d;
    void'($urandom(32'h1C0DE));
    wclk(5);
    chk(sda_oe == 1'b0 && cmd_valid == 1'b0 && rsp_ready == 1'b0 &&
        cmd_first == 1'b0 && cmd_last == 1'b0, "R1 reset outputs",
        {sda_oe, cmd_valid, rsp_ready, cmd_first, cmd_last}, 0);
    rst_n = 1'b1;
    wclk(5);
    chk(sda_line == 1'b1, "R11 line released", int'(sda_line), 1);

    // directed: command only, then command plus arguments on every strap
    wbuf[0] = 8'h3C;
    do_write(7'b1100000, 1);
    for (int s = 0; s < 4; s++) begin
      strap_a1 = s[1];
      strap_a0 = s[0];
      for (int i = 0; i < 8; i++) wbuf[i] = 8'($urandom);
      do_write({5'b11000, s[1:0]}, 3);
      do_write({5'b11000, ~s[1:0]}, 2);
    end

    // directed: read with empty source, read with partial source
    strap_a1 = 1'b1; strap_a0 = 1'b0;
    do_read(7'b1100010, 3, 0, 1'b0);
    do_read(7'b1100010, 4, 2, 1'b0);

    // directed: write closed by repeated START then read (R9)
    base = n_log;
    h_start();
    write_byte({7'b1100010, 1'b0}, ack);
    chk(ack, "R9 write addr ack", int'(ack), 1);
    write_byte(8'h5A, ack);
    wclk(4);
    chk(n_log == base, "R5 byte held until end", n_log - base, 0);
    do_read(7'b1100010, 2, 2, 1'b1);
    chk(n_log - base == 1 && log_d[base] == 8'h5A && log_l[base] && log_f[base],
        "R9 restart closes write", int'(log_d[base]), 8'h5A);

    // constrained random mix
    for (int t = 0; t < 12; t++) begin
      logic [6:0] a;
      int kind;
      strap_a1 = 1'($urandom);
      strap_a0 = 1'($urandom);
      a = ($urandom % 4 != 0) ? {5'b11000, strap_a1, strap_a0} : 7'($urandom);
      kind = $urandom % 2;
      if (kind == 0) begin
        for (int i = 0; i < 8; i++) wbuf[i] = 8'($urandom);
        do_write(a, 1 + int'($urandom % 5));
      end else begin
        do_read(a, 1 + int'($urandom % 4), int'($urandom % 5), 1'b0);
      end
    end

    chk(n_oe_bad == 0, "R6 SDA only moves while SCL low", n_oe_bad, 0);
    d = 8'h00;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule